// File: doc/BRIEF.md
# Banked Cache Identification Register File

This block answers register-bus reads for cache identification in a system-control address window. Two words describe the cache hierarchy and never change at run time: a level descriptor and a cache type word. A third word returns one entry from a sixteen-entry table of cache size descriptors. The entry is chosen by a small selector register that software writes before it reads the size word.

The selector exists twice, once for secure and once for non-secure accesses. The security attribute that comes with each bus access decides which copy is read or written. When the level descriptor reports no caches at all, the selector behaves as a constant zero and discards writes. All identification values arrive as static configuration inputs. Read data is registered.

Top module: `cache_id_regfile`

## Requirements
- R1: A synchronous reset clears both selector copies and the read data register to zero.
- R2: A read at offset 0xD78 returns `cfg_level_id`, and a read at offset 0xD7C returns `cfg_cache_type`.
- R3: Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`. It holds its value while no read is issued.
- R4: A write to offset 0xD84 stores `bus_wdata[3:0]` in the selector. A read of 0xD84 returns that value with bits 31:4 zero.
- R5: The selector copy is chosen by `bus_secure` (1 = secure copy, 0 = non-secure copy). A write to one copy leaves the other copy unchanged.
- R6: A read at offset 0xD80 returns entry k of `cfg_size_bank`, where k is the selector value for the access's security state. Entry k occupies bits [32k+31:32k]. Bit 0 of the selector is the instruction/data flag and bits 3:1 are the level.
- R7: When `cfg_level_id[20:0]` is zero, the selector reads as zero and writes to it are discarded. The stored copies keep their old values, and a size read uses entry 0.
- R8: Writes to offsets 0xD78, 0xD7C and 0xD80 change no state.
- R9: A read at any offset other than the four registers returns zero.
- R10: Address bits 1:0 are ignored when offsets are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access is secure when 1 |
| cfg_level_id | input | 32 | Static cache level descriptor |
| cfg_cache_type | input | 32 | Static cache type word |
| cfg_size_bank | input | 512 | Sixteen packed 32-bit size descriptors, entry 0 in the low bits |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench writes the two selector copies with different values and reads each one back. A design that ignores the security attribute would return the wrong copy or overwrite the other one. It writes data with ones in the upper bits, which exposes a selector that keeps more than four bits. It also writes through offsets whose low two bits are nonzero, which catches a decoder that compares the full address. It then clears the cache-type field, attempts a selector write and restores the field. A design that lets that write through, or that zeroes the stored copy instead of masking it, returns the wrong value when the selector is read back.

// File: rtl/cid_pkg.sv
package cid_pkg;
  localparam int unsigned CID_ADDR_W  = 12;
  localparam logic [CID_ADDR_W-1:0] OFF_LEVEL = 12'hD78;
  localparam logic [CID_ADDR_W-1:0] OFF_TYPE  = 12'hD7C;
  localparam logic [CID_ADDR_W-1:0] OFF_SIZE  = 12'hD80;
  localparam logic [CID_ADDR_W-1:0] OFF_CSEL  = 12'hD84;
  // width of the cache-type field at the bottom of the level descriptor
  localparam int unsigned CTYPE_W = 21;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_TYPE,
    SEL_SIZE,
    SEL_CSEL
  } reg_sel_e;
endpackage

// File: rtl/cid_decode.sv
module cid_decode
  import cid_pkg::*;
#(
  parameter int unsigned ADDR_W = CID_ADDR_W
) (
  input  logic [ADDR_W-3:0] word_addr,
  output reg_sel_e          sel
);
  // compare on word offsets only (byte lane bits dropped by the caller, R10)
  always_comb begin
    sel = SEL_NONE;
    if (word_addr == OFF_LEVEL[ADDR_W-1:2]) sel = SEL_LEVEL;
    else if (word_addr == OFF_TYPE[ADDR_W-1:2]) sel = SEL_TYPE;
    else if (word_addr == OFF_SIZE[ADDR_W-1:2]) sel = SEL_SIZE;
    else if (word_addr == OFF_CSEL[ADDR_W-1:2]) sel = SEL_CSEL;
  end
endmodule

// File: rtl/cid_sel_bank.sv
module cid_sel_bank #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_secure,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             rd_secure,
  input  logic             caches_present,
  output logic [IDX_W-1:0] sel_idx
);
  // copy 0 is non-secure, copy 1 is secure
  logic [IDX_W-1:0] copy_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_copy
    localparam logic IS_SEC = (b == 1);
    always_ff @(posedge clk) begin
      if (rst)
        copy_q[b] <= '0;
      else if (wr_en && caches_present && (wr_secure == IS_SEC))
        copy_q[b] <= wr_idx;
    end
  end

  assign sel_idx = caches_present ? copy_q[rd_secure] : '0;

  assert_sec_store_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en && caches_present && wr_secure |=> copy_q[1] == $past(wr_idx));
  assert_ns_store_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en && caches_present && !wr_secure |=> copy_q[0] == $past(wr_idx));
  assert_ns_isolated_R5: assert property (@(posedge clk) disable iff (rst)
    wr_secure |=> $stable(copy_q[0]));
  assert_sec_isolated_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_secure |=> $stable(copy_q[1]));
  assert_no_cache_wi_R7: assert property (@(posedge clk) disable iff (rst)
    !caches_present |=> $stable(copy_q[0]) && $stable(copy_q[1]));
endmodule

// File: rtl/cid_size_mux.sv
module cid_size_mux #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES*DATA_W-1:0] bank_flat,
  input  logic [IDX_W-1:0]          idx,
  output logic [DATA_W-1:0]         entry
);
  logic [DATA_W-1:0] tbl [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_unpack
    assign tbl[i] = bank_flat[i*DATA_W +: DATA_W];
  end

  assign entry = tbl[idx];
endmodule

// File: rtl/cache_id_regfile.sv
module cache_id_regfile
  import cid_pkg::*;
#(
  parameter int unsigned ADDR_W  = CID_ADDR_W,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      bus_secure,
  input  logic [DATA_W-1:0]         cfg_level_id,
  input  logic [DATA_W-1:0]         cfg_cache_type,
  input  logic [ENTRIES*DATA_W-1:0] cfg_size_bank,
  output logic [DATA_W-1:0]         bus_rdata
);
  reg_sel_e          sel;
  logic              caches_present;
  logic [IDX_W-1:0]  sel_idx;
  logic [DATA_W-1:0] size_word;
  logic              unused_lane_bits;
  logic              unused_wdata_hi;

  assign unused_lane_bits = ^bus_addr[1:0];
  assign unused_wdata_hi  = ^bus_wdata[DATA_W-1:IDX_W];
  assign caches_present   = |cfg_level_id[CTYPE_W-1:0];

  cid_decode #(.ADDR_W(ADDR_W)) decode_i (
    .word_addr (bus_addr[ADDR_W-1:2]),
    .sel       (sel)
  );

  cid_sel_bank #(.IDX_W(IDX_W)) sel_bank_i (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (bus_wr && (sel == SEL_CSEL)),
    .wr_secure      (bus_secure),
    .wr_idx         (bus_wdata[IDX_W-1:0]),
    .rd_secure      (bus_secure),
    .caches_present (caches_present),
    .sel_idx        (sel_idx)
  );

  cid_size_mux #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) size_mux_i (
    .bank_flat (cfg_size_bank),
    .idx       (sel_idx),
    .entry     (size_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (sel)
        SEL_LEVEL: bus_rdata <= cfg_level_id;
        SEL_TYPE:  bus_rdata <= cfg_cache_type;
        SEL_SIZE:  bus_rdata <= size_word;
        SEL_CSEL:  bus_rdata <= {{(DATA_W-IDX_W){1'b0}}, sel_idx};
        default:   bus_rdata <= '0;
      endcase
    end
  end

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (sel == SEL_NONE) |=> bus_rdata == '0);
  assert_csel_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (sel == SEL_CSEL) |=> bus_rdata[DATA_W-1:IDX_W] == '0);
endmodule

// File: tb/cache_id_regfile_tb.sv
module cache_id_regfile_tb_top;
  localparam int unsigned ENTRIES = 16;
  localparam logic [31:0] LEVEL_VAL = 32'h0920_0003;
  localparam logic [31:0] TYPE_VAL  = 32'h8303_C003;
  localparam logic [31:0] NOCACHE   = 32'h0920_0000;

  // op: 0 = write, 1 = read and compare
  typedef struct packed {
    logic        op;
    logic        sec;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 12'hD84, 32'h0,         32'h0,         8'd1},  // R1 secure copy after reset
    '{1'b1, 1'b0, 12'hD84, 32'h0,         32'h0,         8'd1},  // R1 non-secure copy after reset
    '{1'b1, 1'b0, 12'hD78, 32'h0,         LEVEL_VAL,     8'd2},  // R2
    '{1'b1, 1'b1, 12'hD7C, 32'h0,         TYPE_VAL,      8'd2},  // R2
    '{1'b0, 1'b1, 12'hD84, 32'hFFFF_FFF5, 32'h0,         8'd4},
    '{1'b1, 1'b1, 12'hD84, 32'h0,         32'h5,         8'd4},  // R4 upper bits dropped
    '{1'b1, 1'b0, 12'hD84, 32'h0,         32'h0,         8'd5},  // R5 other copy untouched
    '{1'b1, 1'b1, 12'hD80, 32'h0,         32'h5A05_0505, 8'd6},  // R6 entry 5
    '{1'b1, 1'b0, 12'hD80, 32'h0,         32'h5A00_0000, 8'd6},  // R6 entry 0
    '{1'b0, 1'b0, 12'hD84, 32'h0000_000A, 32'h0,         8'd5},
    '{1'b1, 1'b0, 12'hD84, 32'h0,         32'hA,         8'd5},  // R5
    '{1'b1, 1'b1, 12'hD84, 32'h0,         32'h5,         8'd5},  // R5
    '{1'b1, 1'b0, 12'hD80, 32'h0,         32'h5A0A_0A0A, 8'd6},  // R6 entry 10
    '{1'b0, 1'b1, 12'hD78, 32'hFFFF_FFFF, 32'h0,         8'd8},
    '{1'b0, 1'b0, 12'hD80, 32'h0000_0003, 32'h0,         8'd8},
    '{1'b0, 1'b1, 12'hD7C, 32'h0000_0007, 32'h0,         8'd8},
    '{1'b1, 1'b1, 12'hD84, 32'h0,         32'h5,         8'd8},  // R8
    '{1'b1, 1'b0, 12'hD84, 32'h0,         32'hA,         8'd8},  // R8
    '{1'b1, 1'b1, 12'hD88, 32'h0,         32'h0,         8'd9},  // R9
    '{1'b1, 1'b0, 12'h000, 32'h0,         32'h0,         8'd9},  // R9
    '{1'b1, 1'b0, 12'hD7B, 32'h0,         LEVEL_VAL,     8'd10}, // R10
    '{1'b1, 1'b1, 12'hD87, 32'h0,         32'h5,         8'd10}  // R10
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [11:0]  bus_addr = '0;
  logic         bus_rd = 1'b0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_secure = 1'b0;
  logic [31:0]  cfg_level_id = LEVEL_VAL;
  logic [31:0]  cfg_cache_type = TYPE_VAL;
  logic [ENTRIES*32-1:0] cfg_size_bank;
  logic [31:0]  bus_rdata;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  cache_id_regfile dut_i (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_rd         (bus_rd),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_secure     (bus_secure),
    .cfg_level_id   (cfg_level_id),
    .cfg_cache_type (cfg_cache_type),
    .cfg_size_bank  (cfg_size_bank),
    .bus_rdata      (bus_rdata)
  );

  function automatic logic [31:0] bank_val(int i);
    return 32'h5A00_0000 + 32'h0001_0101 * i;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic sec, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_secure = sec; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(logic sec, logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_secure = sec; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) cfg_size_bank[i*32 +: 32] = bank_val(i);
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", bus_rdata, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].op) begin
        do_read(VECS[v].sec, VECS[v].addr, d);
        check($sformatf("R%0d vec%0d", VECS[v].req, v), d, VECS[v].exp);
      end else begin
        do_write(VECS[v].sec, VECS[v].addr, VECS[v].wdata);
      end
    end

    // R3: value lands on the sampling edge and holds over idle cycles
    do_read(1'b0, 12'hD7C, d);
    check("R3 after strobe", d, TYPE_VAL);
    repeat (3) @(negedge clk);
    check("R3 hold", bus_rdata, TYPE_VAL);

    // R10: write through an unaligned offset
    do_write(1'b1, 12'hD86, 32'h0000_000C);
    do_read(1'b1, 12'hD84, d);
    check("R10 unaligned write", d, 32'hC);

    // R7: no cache types reported
    cfg_level_id = NOCACHE;
    do_read(1'b1, 12'hD84, d);
    check("R7 reads zero", d, 32'h0);
    do_read(1'b1, 12'hD80, d);
    check("R7 size entry 0", d, bank_val(0));
    do_write(1'b1, 12'hD84, 32'h3);
    do_write(1'b0, 12'hD84, 32'h6);
    cfg_level_id = LEVEL_VAL;
    do_read(1'b1, 12'hD84, d);
    check("R7 secure write dropped", d, 32'hC);
    do_read(1'b0, 12'hD84, d);
    check("R7 non-secure write dropped", d, 32'hA);
    do_read(1'b1, 12'hD80, d);
    check("R6 entry 12", d, bank_val(12));

    // R1: reset in mid-run clears both copies
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 rdata", bus_rdata, 32'h0);
    do_read(1'b1, 12'hD84, d);
    check("R1 secure cleared", d, 32'h0);
    do_read(1'b0, 12'hD84, d);
    check("R1 non-secure cleared", d, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule